// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why a small microcontroller last came out of reset or out of its stop (low-power) mode. Seven single-cycle event strobes feed it: power-on, external reset pin, watchdog timeout while running, debugger-requested reset, debug-pin wake from stop, GPIO-transition wake from stop, and watchdog wake from stop. When one or more strobes fire, a priority picker selects one event. That event's fixed four-bit cause pattern overwrites the flag register. Software reads the flags at one bus address. Reading that address clears the flags. Writes to the same address do not reach the flags. They are forwarded to a write-only watchdog control register that lives in another block.

The block also filters the active-low external reset pin. The pin must read low on a parameterised number of consecutive clock samples before the block raises a system reset request. A shorter low pulse has no effect. This applies in stop mode as well as in run mode.

The status path is controlled by a two-state machine. STAT_EMPTY means no cause is held and STAT_HELD means a cause is held. The transitions are:
- record: any event moves the machine to STAT_HELD.
- clear: a read in STAT_HELD with no event moves it to STAT_EMPTY.

The pin filter is a three-state machine:
- FLT_IDLE: the pin is high.
- FLT_COUNT: the pin is low and the filter is counting samples. It enters this state on a low sample. It returns to FLT_IDLE on any high sample.
- FLT_ACTIVE: the reset request is asserted. It enters this state on the MIN_LOW-th consecutive low sample. It returns to FLT_IDLE on a high sample.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_n` is released, and before any event, a read returns 0x00 and `sys_rst_req` is 0.
- R2: The cause pattern occupies read-data bits 7..4, with bit 7 = power-on, bit 6 = stop recovery, bit 5 = watchdog and bit 4 = external. The patterns for bits 7..4 are:
  - power-on: 1000
  - pin reset: 0001
  - watchdog reset: 0010
  - debugger reset: 1000
  - debug-pin wake: 1000
  - GPIO wake: 0100
  - watchdog wake: 0110
- R3: Read-data bits 3..0 are always 0.
- R4: While `bus_rd` is high and `bus_addr` equals STAT_ADDR (default 0xF0), `bus_rdata` shows the held flags in that same cycle. At any other address, `bus_rdata` is 0x00 and the flags are not changed.
- R5: A read at STAT_ADDR clears the flags from the following cycle on.
- R6: A new event replaces all four flags with its own pattern. Patterns are not merged. When an event and a read occur in the same cycle, the event's pattern is what remains held.
- R7: When several strobes fire together, one event is recorded, chosen in this order: power-on, pin, debugger, watchdog, debug-pin wake, GPIO wake, watchdog wake.
- R8: A write at STAT_ADDR leaves the flags unchanged. The write also drives `wdog_ctl_we` high in that cycle, with `wdog_ctl_wdata` equal to `bus_wdata`.
- R9: With no event and no read at STAT_ADDR, the flags hold their value. For example, 0x80 after power-on is kept for any number of cycles.
- R10: `sys_rst_req` rises after the clock edge that takes the MIN_LOW-th consecutive low sample of `rst_pin_n` (default 4). Any high sample restarts the count. A pulse of fewer samples never raises the request.
- R11: While the request is high, a high sample of `rst_pin_n` lowers `sys_rst_req` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ev_por | input | 1 | Power-on event strobe |
| ev_pin | input | 1 | External pin reset event strobe |
| ev_wdt | input | 1 | Watchdog timeout (running) strobe |
| ev_dbg | input | 1 | Debugger reset strobe |
| ev_dbgwake | input | 1 | Debug-pin stop wake strobe |
| ev_gpiowake | input | 1 | GPIO stop wake strobe |
| ev_wdtwake | input | 1 | Watchdog stop wake strobe |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| wdog_ctl_we | output | 1 | Forwarded write enable for the watchdog control register |
| wdog_ctl_wdata | output | 8 | Forwarded write data |
| rst_pin_n | input | 1 | Active-low external reset pin (already synchronised) |
| sys_rst_req | output | 1 | Filtered system reset request |

## Verification
Each event is tried alone to confirm its own four-bit pattern. Events are then tried as descending sets of simultaneous strobes, so that the recorded pattern shows which strobe took priority. Because debugger, debug-pin wake and power-on share one pattern, the sets are arranged so that each priority step changes the visible result. Sequences of two events without a read in between separate overwrite from accumulation. An event arriving in the same cycle as a read separates "event wins" from "read wins". On the pin filter, the bench uses a pulse one sample short, a broken pulse, and a pulse of exactly the threshold length, which together locate the threshold precisely.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_POR,
        EV_PIN,
        EV_DBG,
        EV_WDT,
        EV_DBGWAKE,
        EV_GPIOWAKE,
        EV_WDTWAKE
    } rst_event_e;

    // {power-on, stop recovery, watchdog, external}
    typedef logic [3:0] cause_flags_t;

    typedef enum logic [1:0] {
        FLT_IDLE,
        FLT_COUNT,
        FLT_ACTIVE
    } filt_state_e;

    typedef enum logic {
        STAT_EMPTY,
        STAT_HELD
    } stat_state_e;

    function automatic cause_flags_t pattern_of(input rst_event_e ev);
        cause_flags_t p;
        unique case (ev)
            EV_POR:      p = 4'b1000;
            EV_PIN:      p = 4'b0001;
            EV_DBG:      p = 4'b1000;
            EV_WDT:      p = 4'b0010;
            EV_DBGWAKE:  p = 4'b1000;
            EV_GPIOWAKE: p = 4'b0100;
            EV_WDTWAKE:  p = 4'b0110;
            default:     p = 4'b0000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rst_event_pick.sv
module rst_event_pick
    import rst_cause_pkg::*;
(
    input  logic       ev_por,
    input  logic       ev_pin,
    input  logic       ev_wdt,
    input  logic       ev_dbg,
    input  logic       ev_dbgwake,
    input  logic       ev_gpiowake,
    input  logic       ev_wdtwake,
    output rst_event_e ev_sel
);

    // Fixed priority: resets before wakes, power-on highest.
    always_comb begin
        if (ev_por)           ev_sel = EV_POR;
        else if (ev_pin)      ev_sel = EV_PIN;
        else if (ev_dbg)      ev_sel = EV_DBG;
        else if (ev_wdt)      ev_sel = EV_WDT;
        else if (ev_dbgwake)  ev_sel = EV_DBGWAKE;
        else if (ev_gpiowake) ev_sel = EV_GPIOWAKE;
        else if (ev_wdtwake)  ev_sel = EV_WDTWAKE;
        else                  ev_sel = EV_NONE;
    end

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
    import rst_cause_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  rst_event_e   ev_sel,
    input  logic         rd_hit,
    output cause_flags_t flags
);

    stat_state_e  state_q, state_d;
    cause_flags_t flags_q, flags_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STAT_EMPTY;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    // Next state: an event always records; a read only clears when no event.
    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        if (ev_sel != EV_NONE) begin
            state_d = STAT_HELD;
            flags_d = pattern_of(ev_sel);
        end else begin
            unique case (state_q)
                STAT_EMPTY: begin
                    state_d = STAT_EMPTY;
                end
                STAT_HELD: begin
                    if (rd_hit) begin
                        state_d = STAT_EMPTY;
                        flags_d = '0;
                    end
                end
                default: begin
                    state_d = STAT_EMPTY;
                    flags_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        flags = flags_q;
    end

endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter
    import rst_cause_pkg::*;
#(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req
);

    localparam int CNT_W = $clog2(MIN_LOW + 1);

    filt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_IDLE: begin
                cnt_d = '0;
                if (!pin_n) begin
                    if (MIN_LOW <= 1) begin
                        state_d = FLT_ACTIVE;
                    end else begin
                        state_d = FLT_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FLT_COUNT: begin
                if (pin_n) begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(MIN_LOW - 1)) begin
                    state_d = FLT_ACTIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            FLT_ACTIVE: begin
                if (pin_n) state_d = FLT_IDLE;
            end
            default: begin
                state_d = FLT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        req = (state_q == FLT_ACTIVE);
    end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF0,
    parameter int              MIN_LOW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_por,
    input  logic              ev_pin,
    input  logic              ev_wdt,
    input  logic              ev_dbg,
    input  logic              ev_dbgwake,
    input  logic              ev_gpiowake,
    input  logic              ev_wdtwake,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdog_ctl_we,
    output logic [7:0]        wdog_ctl_wdata,
    input  logic              rst_pin_n,
    output logic              sys_rst_req
);

    rst_event_e   ev_sel;
    cause_flags_t cause_q;
    logic         addr_hit;
    logic         rd_hit;

    always_comb begin
        addr_hit = (bus_addr == STAT_ADDR);
        rd_hit   = bus_rd && addr_hit;
    end

    rst_event_pick u_pick (
        .ev_por      (ev_por),
        .ev_pin      (ev_pin),
        .ev_wdt      (ev_wdt),
        .ev_dbg      (ev_dbg),
        .ev_dbgwake  (ev_dbgwake),
        .ev_gpiowake (ev_gpiowake),
        .ev_wdtwake  (ev_wdtwake),
        .ev_sel      (ev_sel)
    );

    rst_cause_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_sel (ev_sel),
        .rd_hit (rd_hit),
        .flags  (cause_q)
    );

    rst_pin_filter #(.MIN_LOW(MIN_LOW)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rst_pin_n),
        .req   (sys_rst_req)
    );

    always_comb begin
        bus_rdata      = rd_hit ? {cause_q, 4'b0000} : 8'h00;
        wdog_ctl_we    = bus_wr && addr_hit;
        wdog_ctl_wdata = bus_wdata;
    end

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF0,
    parameter int                MIN_LOW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_por,
    input logic              ev_pin,
    input logic              ev_wdt,
    input logic              ev_dbg,
    input logic              ev_dbgwake,
    input logic              ev_gpiowake,
    input logic              ev_wdtwake,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic [3:0]        flags,
    input logic              rst_pin_n,
    input logic              sys_rst_req
);

    logic any_ev;
    logic hit;

    always_comb begin
        any_ev = ev_por | ev_pin | ev_wdt | ev_dbg | ev_dbgwake | ev_gpiowake | ev_wdtwake;
        hit    = (bus_addr == STAT_ADDR);
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[3:0] == 4'b0000); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && !any_ev) |=> (flags == 4'b0000)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !(bus_rd && hit)) |=> $stable(flags)); // R9

    AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !any_ev) |=> $stable(flags)); // R8

    AST_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (flags == 4'b1000)); // R7

    AST_OFF_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == 8'h00)); // R4

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && rst_pin_n) |=> !sys_rst_req); // R11

    AST_REQ_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> $past(!rst_pin_n)); // R10

endmodule

bind rst_cause_reg rst_cause_chk #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .MIN_LOW   (MIN_LOW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_por      (ev_por),
    .ev_pin      (ev_pin),
    .ev_wdt      (ev_wdt),
    .ev_dbg      (ev_dbg),
    .ev_dbgwake  (ev_dbgwake),
    .ev_gpiowake (ev_gpiowake),
    .ev_wdtwake  (ev_wdtwake),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .flags       (cause_q),
    .rst_pin_n   (rst_pin_n),
    .sys_rst_req (sys_rst_req)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;

    localparam int ADDR_W  = 8;
    localparam int MIN_LOW = 4;
    localparam logic [7:0] STAT = 8'hF0;

    // {por, pin, dbg, wdt, dbgwake, gpiowake, wdtwake} , expected bits 7..4
    localparam int NVEC = 13;
    localparam logic [10:0] VECS [NVEC] = '{
        {7'b1000000, 4'b1000},
        {7'b0100000, 4'b0001},
        {7'b0001000, 4'b0010},
        {7'b0010000, 4'b1000},
        {7'b0000100, 4'b1000},
        {7'b0000010, 4'b0100},
        {7'b0000001, 4'b0110},
        {7'b1111111, 4'b1000},
        {7'b0111111, 4'b0001},
        {7'b0011111, 4'b1000},
        {7'b0001111, 4'b0010},
        {7'b0000111, 4'b1000},
        {7'b0000011, 4'b0100}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic ev_por = 0, ev_pin = 0, ev_wdt = 0, ev_dbg = 0;
    logic ev_dbgwake = 0, ev_gpiowake = 0, ev_wdtwake = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic wdog_ctl_we;
    logic [7:0] wdog_ctl_wdata;
    logic rst_pin_n = 1;
    logic sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    rst_cause_reg #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT), .MIN_LOW(MIN_LOW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_por(ev_por), .ev_pin(ev_pin), .ev_wdt(ev_wdt), .ev_dbg(ev_dbg),
        .ev_dbgwake(ev_dbgwake), .ev_gpiowake(ev_gpiowake), .ev_wdtwake(ev_wdtwake),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdog_ctl_we(wdog_ctl_we), .wdog_ctl_wdata(wdog_ctl_wdata),
        .rst_pin_n(rst_pin_n), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [6:0] m);
        {ev_por, ev_pin, ev_dbg, ev_wdt, ev_dbgwake, ev_gpiowake, ev_wdtwake} = m;
    endtask

    // One cycle of events; returns after edge, strobes cleared.
    task automatic pulse_ev(input logic [6:0] m);
        set_ev(m);
        @(posedge clk); #1;
        set_ev(7'b0);
    endtask

    // Read: sample same cycle, then let the edge pass.
    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1; #1;
        d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    initial begin
        #400000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        do_read(STAT, rv);
        check("R1 read after reset", rv, 8'h00);
        check("R1 req after reset", {7'b0, sys_rst_req}, 8'h00);

        // R2 / R7 vector table
        for (int i = 0; i < NVEC; i++) begin
            pulse_ev(VECS[i][10:4]);
            do_read(STAT, rv);
            check($sformatf("R2/R7 vec %0d", i), rv, {VECS[i][3:0], 4'b0000});
            check("R3 low nibble", {4'b0, rv[3:0]}, 8'h00);
            do_read(STAT, rv);
            check("R5 cleared after read", rv, 8'h00);
        end

        // R9 power-on hold
        pulse_ev(7'b1000000);
        repeat (20) @(posedge clk); #1;
        do_read(STAT, rv);
        check("R9 hold 0x80", rv, 8'h80);

        // R4 other address gives 0 and does not clear
        pulse_ev(7'b0000010);
        do_read(8'hF1, rv);
        check("R4 off-address read", rv, 8'h00);
        do_read(STAT, rv);
        check("R4 flags untouched", rv, 8'h40);

        // R8 write has no effect, is forwarded
        pulse_ev(7'b0001000);
        bus_addr = STAT; bus_wr = 1; bus_wdata = 8'h5A; #1;
        check("R8 we forwarded", {7'b0, wdog_ctl_we}, 8'h01);
        check("R8 wdata forwarded", wdog_ctl_wdata, 8'h5A);
        @(posedge clk); #1 bus_wr = 0;
        do_read(STAT, rv);
        check("R8 flags after write", rv, 8'h20);

        // R6 overwrite, no merge
        pulse_ev(7'b1000000);
        pulse_ev(7'b0000010);
        do_read(STAT, rv);
        check("R6 overwrite", rv, 8'h40);

        // R6 event and read same cycle: event wins
        pulse_ev(7'b0100000);
        set_ev(7'b0000001);
        do_read(STAT, rv);
        set_ev(7'b0);
        check("R4 same-cycle read shows old", rv, 8'h10);
        do_read(STAT, rv);
        check("R6 event beats read", rv, 8'h60);

        // R10 short pulse ignored
        rst_pin_n = 0;
        repeat (MIN_LOW - 1) @(posedge clk); #1;
        check("R10 short pulse", {7'b0, sys_rst_req}, 8'h00);
        rst_pin_n = 1;
        repeat (3) @(posedge clk); #1;
        check("R10 after short pulse", {7'b0, sys_rst_req}, 8'h00);

        // R10 broken pulse restarts count
        rst_pin_n = 0;
        repeat (MIN_LOW - 1) @(posedge clk); #1;
        rst_pin_n = 1;
        @(posedge clk); #1;
        rst_pin_n = 0;
        repeat (MIN_LOW - 1) @(posedge clk); #1;
        check("R10 restart count", {7'b0, sys_rst_req}, 8'h00);
        @(posedge clk); #1;
        check("R10 threshold reached", {7'b0, sys_rst_req}, 8'h01);

        // R11 release
        rst_pin_n = 1;
        @(posedge clk); #1;
        check("R11 request drops", {7'b0, sys_rst_req}, 8'h00);

        // R10 exact length from idle
        rst_pin_n = 0;
        repeat (MIN_LOW) @(posedge clk); #1;
        check("R10 exact length", {7'b0, sys_rst_req}, 8'h01);
        rst_pin_n = 1;
        @(posedge clk); #1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule